// File: doc/BRIEF.md
# Software-Paced Serial EEPROM Control Port

This block is one host-visible control word that lets software run a four-wire serial EEPROM by setting and clearing individual bits. Software writes the chip-select, serial clock and serial data-in levels. It reads back the EEPROM's data-out level, a pacing flag that says when the next bit change is allowed, and a strap that records which device size is fitted.

The serial clock and data-in levels share two pins of the memory address bus. An enable bit in the same word selects what those pins carry. When the enable is set, the pins carry the EEPROM lines. When it is clear, they carry the normal address. Chip-select has a dedicated pin and is never muxed.

After any write that changes a line level, the pacing flag stays low for a programmable number of cycles. Software polls the flag before it makes the next change, which keeps the EEPROM's setup and hold windows met without any protocol logic in hardware.

Top module: `eeprom_bitbang_port`

## Requirements
- R1: After a synchronous reset, bits 3..0 of the control word are 0, `ee_cs_o` is 0, and the first read word after reset is released shows the strap in bit 6, the ready flag (bit 5) as 1 and all other bits as 0.
- R2: `ee_cs_o` equals bit 1 of the last write from the clock edge that accepts the write, whatever the value of the enable bit (bit 0).
- R3: While enable (bit 0) is 1, `mem_addr_o[14]` carries the serial clock bit (bit 2) and `mem_addr_o[13]` carries the data-in bit (bit 3). All other address bits carry `bus_addr_i`. The pins are registered one cycle behind their sources.
- R4: While enable is 0, `mem_addr_o` equals `bus_addr_i` delayed by one clock.
- R5: The written bits 3..0 (enable, chip-select, serial clock, data-in) read back unchanged in the same positions.
- R6: Bit 4 shows `mem_d31_i` after a two-flop synchroniser. A change on the input before edge j appears in `rd_data_o` after edge j+2.
- R7: A write that changes bit 1, 2 or 3 forces the ready flag (bit 5) low for SETTLE_CYC cycles. It reads 0 after edges k+1 through k+SETTLE_CYC, where k is the accepting edge, and 1 after edge k+SETTLE_CYC+1. A further such write reloads the window.
- R8: A write that changes only the enable bit, or that rewrites bits 3..1 with the values they already hold, leaves the ready flag unaffected.
- R9: Bit 6 holds the value of `size_strap_i` sampled while reset is asserted (1 = small organisations of 16 or 64 sixteen-bit words, 0 = large organisations of 128 or 256). Strap changes after reset are ignored.
- R10: Bits 31..7 always read 0, and write data in bits 31..4 has no effect.
- R11: `rd_data_o` is a registered snapshot of the control state. The bits of a write accepted at edge k are visible after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples the size strap |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | REG_W | Write data |
| rd_data_o | output | REG_W | Registered control word readback |
| size_strap_i | input | 1 | Device size strap |
| mem_d31_i | input | 1 | Memory data bus bit 31, EEPROM data-out |
| bus_addr_i | input | ADDR_W | Normal memory address from the rest of the chip |
| mem_addr_o | output | ADDR_W | Shared memory address pins |
| ee_cs_o | output | 1 | EEPROM chip-select pin |

## Verification
Each result has its own latency. Chip-select is due one edge after the accepting write. The address pins and the readback word are due one edge after the state they mirror, which is two edges after a write. The data-out bit is due three edges after the input changes. The ready flag stays low for SETTLE_CYC readback samples that start one edge after the write. The bench keeps to this with a cycle-level reference model advanced on every rising edge and compared at every falling edge, so each result is checked exactly when it falls due. Directed sequences also count falling edges from the write to probe both edges of the ready window, the synchroniser delay and the strap hold.

// File: rtl/eeprom_port_pkg.sv
package eeprom_port_pkg;
  // bit positions in the control word; software depends on these
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned CS_BIT   = 1;
  localparam int unsigned SK_BIT   = 2;
  localparam int unsigned DI_BIT   = 3;
  localparam int unsigned DO_BIT   = 4;
  localparam int unsigned RDY_BIT  = 5;
  localparam int unsigned SIZE_BIT = 6;
  localparam int unsigned CTRL_W   = 4;
  localparam int unsigned USED_W   = 7;

  // writable part of the word, LSB first is enable
  typedef struct packed {
    logic din;
    logic sclk;
    logic csel;
    logic enable;
  } ee_ctrl_t;
endpackage

// File: rtl/ee_ctrl_reg.sv
module ee_ctrl_reg
  import eeprom_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_bits_i,
  input  logic              strap_i,
  output ee_ctrl_t          ctrl_o,
  output logic              strap_o,
  output logic              pin_change_o
);
  ee_ctrl_t ctrl_q;
  logic     strap_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= ee_ctrl_t'(wr_bits_i);
  end

  // the strap is sampled for as long as reset is held
  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_i;
  end

  // a write that moves any pin-level bit restarts pacing
  assign pin_change_o = wr_en_i &&
    (wr_bits_i[DI_BIT:CS_BIT] != {ctrl_q.din, ctrl_q.sclk, ctrl_q.csel});

  assign ctrl_o  = ctrl_q;
  assign strap_o = strap_q;

  AST_CS_TRACK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en_i)) |-> (ctrl_o.csel == $past(wr_bits_i[CS_BIT]))); // R2
  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(strap_o)); // R9
endmodule

// File: rtl/ee_settle_timer.sv
module ee_settle_timer #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic ready_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load_i) cnt_q <= CNT_W'(SETTLE_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign ready_o = (cnt_q == '0);

  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !ready_o); // R7
  AST_READY_RECOVER: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q == CNT_W'(1)) |=> ready_o); // R7
endmodule

// File: rtl/ee_sync.sv
module ee_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= 1'b0;
        else stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= 1'b0;
        else stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ee_pin_mux.sv
module ee_pin_mux
  import eeprom_port_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned CLK_PIN = 14,
  parameter int unsigned DIN_PIN = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  ee_ctrl_t          ctrl_i,
  output logic [ADDR_W-1:0] mem_addr_o
);
  logic [ADDR_W-1:0] pick;
  logic [ADDR_W-1:0] addr_q;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i == CLK_PIN) begin : g_clk
      assign pick[i] = ctrl_i.enable ? ctrl_i.sclk : bus_addr_i[i];
    end else if (i == DIN_PIN) begin : g_din
      assign pick[i] = ctrl_i.enable ? ctrl_i.din : bus_addr_i[i];
    end else begin : g_pass
      assign pick[i] = bus_addr_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else addr_q <= pick;
  end

  assign mem_addr_o = addr_q;

  AST_PIN_SHARED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl_i.enable)) |->
      (mem_addr_o[CLK_PIN] == $past(ctrl_i.sclk) &&
       mem_addr_o[DIN_PIN] == $past(ctrl_i.din))); // R3
  AST_PIN_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctrl_i.enable)) |-> (mem_addr_o == $past(bus_addr_i))); // R4
endmodule

// File: rtl/eeprom_bitbang_port.sv
module eeprom_bitbang_port
  import eeprom_port_pkg::*;
#(
  parameter int unsigned REG_W       = 32,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned CLK_PIN     = 14,
  parameter int unsigned DIN_PIN     = 13,
  parameter int unsigned SETTLE_CYC  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              size_strap_i,
  input  logic              mem_d31_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              ee_cs_o
);
  ee_ctrl_t   ctrl;
  logic       strap;
  logic       pin_change;
  logic       ready;
  logic       dout_s;
  logic [REG_W-1:0] rd_next;
  logic [REG_W-1:0] rd_q;

  ee_ctrl_reg u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .wr_en_i      (wr_en_i),
    .wr_bits_i    (wr_data_i[CTRL_W-1:0]),
    .strap_i      (size_strap_i),
    .ctrl_o       (ctrl),
    .strap_o      (strap),
    .pin_change_o (pin_change)
  );

  ee_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load_i  (pin_change),
    .ready_o (ready)
  );

  ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (mem_d31_i),
    .q_o (dout_s)
  );

  ee_pin_mux #(
    .ADDR_W  (ADDR_W),
    .CLK_PIN (CLK_PIN),
    .DIN_PIN (DIN_PIN)
  ) u_mux (
    .clk        (clk),
    .rst        (rst),
    .bus_addr_i (bus_addr_i),
    .ctrl_i     (ctrl),
    .mem_addr_o (mem_addr_o)
  );

  always_comb begin
    rd_next                 = '0;
    rd_next[CTRL_W-1:0]     = ctrl;
    rd_next[DO_BIT]         = dout_s;
    rd_next[RDY_BIT]        = ready;
    rd_next[SIZE_BIT]       = strap;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else rd_q <= rd_next;
  end

  assign rd_data_o = rd_q;
  assign ee_cs_o   = ctrl.csel;

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en_i) && |$past(wr_data_i[REG_W-1:CTRL_W])) |->
      (rd_data_o[REG_W-1:USED_W] == '0)); // R10
  AST_RD_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_data_o[CTRL_W-1:0] == $past(ctrl))); // R11
endmodule

// File: tb/eeprom_bitbang_port_tb.sv
module eeprom_bitbang_port_tb_top;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned SETTLE = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [REG_W-1:0]  wr_data = '0;
  logic [REG_W-1:0]  rd_data;
  logic              strap = 1'b1;
  logic              d31 = 1'b0;
  logic [ADDR_W-1:0] bus = '0;
  logic [ADDR_W-1:0] maddr;
  logic              cs;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  eeprom_bitbang_port #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .CLK_PIN(14), .DIN_PIN(13),
    .SETTLE_CYC(SETTLE), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .size_strap_i(strap), .mem_d31_i(d31),
    .bus_addr_i(bus), .mem_addr_o(maddr), .ee_cs_o(cs)
  );

  // reference model built from the requirements
  logic [3:0]        m_ctrl = '0;
  int unsigned       m_cnt  = 0;
  logic              m_strap = 1'b0;
  logic              m_s1 = 1'b0, m_s2 = 1'b0;
  logic [REG_W-1:0]  m_rd = '0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic              m_addr_en = 1'b0;
  bit                m_live = 1'b0;

  function automatic logic [ADDR_W-1:0] exp_pins(logic [3:0] c, logic [ADDR_W-1:0] b);
    logic [ADDR_W-1:0] r;
    r = b;
    if (c[0]) begin
      r[14] = c[2];
      r[13] = c[3];
    end
    return r;
  endfunction

  function automatic logic [REG_W-1:0] exp_word(logic [3:0] c, logic s2, int unsigned cnt, logic st);
    logic [REG_W-1:0] r;
    r = '0;
    r[3:0] = c;
    r[4] = s2;
    r[5] = (cnt == 0);
    r[6] = st;
    return r;
  endfunction

  always @(posedge clk) begin
    m_live <= 1'b1;
    if (rst) begin
      m_ctrl <= '0; m_cnt <= 0; m_strap <= strap;
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_rd <= '0; m_addr <= '0; m_addr_en <= 1'b0;
    end else begin
      if (wr_en) m_ctrl <= wr_data[3:0];
      if (wr_en && wr_data[3:1] != m_ctrl[3:1]) m_cnt <= SETTLE;
      else if (m_cnt != 0) m_cnt <= m_cnt - 1;
      m_s1 <= d31;
      m_s2 <= m_s1;
      m_rd <= exp_word(m_ctrl, m_s2, m_cnt, m_strap);
      m_addr <= exp_pins(m_ctrl, bus);
      m_addr_en <= m_ctrl[0];
    end
  end

  task automatic chk(input string req, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, at the falling edge
  always @(negedge clk) begin
    if (m_live && !rst && !done) begin
      chk("R2 chip-select", {31'b0, cs}, {31'b0, m_ctrl[1]});
      if (m_addr_en) chk("R3 shared pins", {16'b0, maddr}, {16'b0, m_addr});
      else           chk("R4 bypass pins", {16'b0, maddr}, {16'b0, m_addr});
      chk("R5 written bits", {28'b0, rd_data[3:0]}, {28'b0, m_rd[3:0]});
      chk("R6 data-out", {31'b0, rd_data[4]}, {31'b0, m_rd[4]});
      chk("R7 ready", {31'b0, rd_data[5]}, {31'b0, m_rd[5]});
      chk("R9 strap", {31'b0, rd_data[6]}, {31'b0, m_rd[6]});
      chk("R10 upper zero", {7'b0, rd_data[31:7]}, 32'b0);
      chk("R11 snapshot", rd_data, m_rd);
    end
  end

  task automatic write_word(input logic [REG_W-1:0] v);
    wr_data = v;
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    strap = 1'b0;  // R9: change after reset must be ignored
    @(negedge clk);
    chk("R1 reset word", rd_data, 32'h0000_0060);
    chk("R1 reset cs", {31'b0, cs}, 32'b0);

    // R7: pacing window after a chip-select change
    write_word(32'h2);
    for (int i = 1; i <= SETTLE; i++) begin
      @(negedge clk);
      chk("R7 ready low", {31'b0, rd_data[5]}, 32'b0);
    end
    @(negedge clk);
    chk("R7 ready back", {31'b0, rd_data[5]}, 32'b1);

    // R8: toggling only enable leaves ready high
    write_word(32'h3);
    for (int i = 0; i <= SETTLE; i++) begin
      @(negedge clk);
      chk("R8 ready kept", {31'b0, rd_data[5]}, 32'b1);
    end
    // R8: rewriting the same levels leaves ready high
    write_word(32'h3);
    @(negedge clk);
    chk("R8 same levels", {31'b0, rd_data[5]}, 32'b1);

    // R2: chip-select with enable clear
    write_word(32'h2);
    chk("R2 cs without enable", {31'b0, cs}, 32'b1);

    // R10: upper write data has no effect
    write_word(32'hFFFF_FFF0);
    @(negedge clk);
    chk("R10 upper ignored", rd_data & 32'hFFFF_FF8F, 32'h0);

    // R6: synchroniser delay
    repeat (SETTLE + 2) @(negedge clk);
    d31 = 1'b1;
    @(negedge clk);
    chk("R6 not yet 1", {31'b0, rd_data[4]}, 32'b0);
    @(negedge clk);
    chk("R6 not yet 2", {31'b0, rd_data[4]}, 32'b0);
    @(negedge clk);
    chk("R6 visible", {31'b0, rd_data[4]}, 32'b1);

    // R3/R4 under random stimulus, fixed seed
    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++) begin
      bus   = ADDR_W'($urandom);
      d31   = ($urandom % 4) == 0 ? ~d31 : d31;
      wr_en = ($urandom % 3) == 0;
      wr_data = $urandom;
      @(negedge clk);
    end
    wr_en = 1'b0;

    // R9: relatch strap with a second reset
    rst = 1'b1;
    strap = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    strap = 1'b1;
    @(negedge clk);
    chk("R1 R9 second reset", rd_data & 32'h0000_006F, 32'h0000_0020);
    repeat (4) @(negedge clk);
    chk("R9 strap held", {31'b0, rd_data[6]}, 32'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule